// File: doc/BRIEF.md
# Bus Region Decoder with Per-Region Wait States

This block sits between a processor's load/store port and a small set of memory-mapped targets. For each request it first checks that the address suits the access width. It then compares the address against a table of regions. Every region covers a power-of-two window at an aligned base. The decoder selects one target, passes it the offset within its window, and holds the selection for a programmable number of wait cycles. It then completes the access. When no access can start, it answers with an alignment fault or a bus error instead.

One table entry may be marked as the memory-controller region. That region is matched ahead of all others and does not depend on a valid bit. Every other region matches only while its valid bit is set, and a lower index wins an overlap among them. Each region has its own signed read and write delay, and a negative value marks that direction as forbidden. Each region also has its own set of supported access widths. Software programs the table through a word-wide write port: base, size, flags and delays. The size written is rounded up to the next power of two.

Top module: `region_decoder`

## Requirements
- R1: After reset every region is invalid and has no controller flag, no capabilities and zero delays, so any access completes as a bus error; `rsp_ready` is low until an accepted request completes.
- R2: A size write stores a mask equal to the size rounded up to a power of two, minus one. The target receives `addr & mask` on `tgt_offset`, and an address just past the rounded window does not hit. A size of 0 selects the whole address space.
- R3: An address hits a region when the bits outside its mask equal those of the region base. A hit read returns the selected target's `tgt_rdata` slice on `rsp_rdata`.
- R4: A region with the controller flag (flag bit 1) hits whatever its valid bit, and it wins over any other matching region. At most one region carries that flag.
- R5: A region without the controller flag hits only while its valid flag (flag bit 0) is set. Among such regions, the lowest index wins, and `tgt_sel` is one-hot or zero.
- R6: A word access (size code 2) with `addr[1:0]` nonzero, or a half-word access (size code 1) with `addr[0]` set, completes with `rsp_align_fault`. No target is selected in that case. Byte accesses (size code 0) never fault on alignment.
- R7: An access that hits no region completes with `rsp_bus_err`, with `rsp_fault_addr` equal to the request address and `rsp_rdata` equal to zero.
- R8: A successful access completes `d+1` cycles after acceptance, where `d` is the region's read delay (delay field bits [7:0]) or write delay (bits [15:8]). `tgt_sel`, `tgt_we`, `tgt_offset` and `tgt_wdata` are held throughout.
- R9: When the delay for the requested direction is negative (sign bit set), the access completes one cycle after acceptance with `rsp_bus_err`.
- R10: An access whose width the region does not support completes with `rsp_bus_err`. The capability flag bits are 2 for byte, 3 for half-word and 4 for word. Size code 3 is always a bus error.
- R11: A table write (`cfg_we`) issued while an access is in flight is discarded. A request presented in the same cycle as a table write waits.
- R12: `rsp_ready` is high for exactly one cycle per accepted request, and the two fault outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until `rsp_ready` |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Physical request address |
| req_wdata | input | DATA_W | Store data |
| rsp_ready | output | 1 | Completion strobe, one cycle |
| rsp_align_fault | output | 1 | Completion was an alignment fault |
| rsp_bus_err | output | 1 | Completion was a bus error |
| rsp_rdata | output | DATA_W | Load data on successful read completion, else zero |
| rsp_fault_addr | output | ADDR_W | Faulting address while a fault output is high, else zero |
| tgt_sel | output | NUM_RGN | One-hot target select, held during the access |
| tgt_we | output | 1 | Write strobe qualifier for the selected target |
| tgt_size | output | 2 | Access width code for the target |
| tgt_offset | output | ADDR_W | Offset within the selected region |
| tgt_wdata | output | DATA_W | Store data for the target |
| tgt_rdata | input | NUM_RGN*DATA_W | Read data of every target, region r in slice r |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Region index to program |
| cfg_field | input | 2 | 0 base, 1 size, 2 flags, 3 delays |
| cfg_wdata | input | ADDR_W | Field value |

## Verification
The inline properties watch the invariants on every cycle. They check that the target select is one-hot, that it is held while wait states run, and that no target is driven on a fault. They also check that the completion strobe lasts a single cycle, that the two fault kinds exclude each other, that a failed read returns zero, that table contents stay frozen when a write arrives during an access, and that no more than one controller region exists. Only the bench's scenarios can show the decode results themselves. These are which region wins an overlap, the offset after power-of-two rounding, the exact cycle count for each region and direction, and the rejection of forbidden directions and unsupported widths. They also include the effect of clearing a valid bit on the next access.

// File: rtl/region_decoder_pkg.sv
package region_decoder_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      FLD_BASE  = 2'd0,
      FLD_SIZE  = 2'd1,
      FLD_FLAGS = 2'd2,
      FLD_DELAY = 2'd3
   } cfg_field_e;

   localparam int FLG_VALID = 0;
   localparam int FLG_CTRL  = 1;
   localparam int FLG_CAP8  = 2;
   localparam int FLG_CAP16 = 3;
   localparam int FLG_CAP32 = 4;
   localparam int FLG_W     = 5;

endpackage

// File: rtl/rd_region_table.sv
module rd_region_table
   import region_decoder_pkg::*;
#(
   parameter  int NUM_RGN = 4,
   parameter  int ADDR_W  = 32,
   parameter  int DLY_W   = 8,
   localparam int IDX_W   = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [IDX_W-1:0]                   wr_idx,
   input  logic [1:0]                         wr_field,
   input  logic [ADDR_W-1:0]                  wr_data,
   output logic [NUM_RGN-1:0][ADDR_W-1:0]     base_o,
   output logic [NUM_RGN-1:0][ADDR_W-1:0]     smask_o,
   output logic [NUM_RGN-1:0][FLG_W-1:0]      flags_o,
   output logic [NUM_RGN-1:0][DLY_W-1:0]      rdly_o,
   output logic [NUM_RGN-1:0][DLY_W-1:0]      wdly_o
);

   logic [ADDR_W-1:0]  sz_m1;
   logic [ADDR_W-1:0]  sz_mask;
   logic [NUM_RGN-1:0] ctrl_v;

   // round the written size up to a power of two: smear every set bit of size-1 downward
   assign sz_m1 = wr_data - ADDR_W'(1);

   for (genvar b = 0; b < ADDR_W; b++) begin : g_smear
      assign sz_mask[b] = |sz_m1[ADDR_W-1:b];
   end

   for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_o[r]  <= '0;
            smask_o[r] <= '0;
            flags_o[r] <= '0;
            rdly_o[r]  <= '0;
            wdly_o[r]  <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(r))) begin
            case (cfg_field_e'(wr_field))
               FLD_BASE:  base_o[r]  <= wr_data;
               FLD_SIZE:  smask_o[r] <= sz_mask;
               FLD_FLAGS: flags_o[r] <= wr_data[FLG_W-1:0];
               default: begin
                  rdly_o[r] <= wr_data[DLY_W-1:0];
                  wdly_o[r] <= wr_data[2*DLY_W-1:DLY_W];
               end
            endcase
         end
      end
      assign ctrl_v[r] = flags_o[r][FLG_CTRL];
   end

   // R4: software must never mark two controller regions
   p_ctrl_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ctrl_v) <= 1);

endmodule

// File: rtl/rd_match.sv
module rd_match
   import region_decoder_pkg::*;
#(
   parameter  int NUM_RGN = 4,
   parameter  int ADDR_W  = 32,
   localparam int IDX_W   = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
   input  logic [ADDR_W-1:0]              addr_i,
   input  logic [NUM_RGN-1:0][ADDR_W-1:0] base_i,
   input  logic [NUM_RGN-1:0][ADDR_W-1:0] smask_i,
   input  logic [NUM_RGN-1:0][FLG_W-1:0]  flags_i,
   output logic                           hit_o,
   output logic [IDX_W-1:0]               idx_o,
   output logic [ADDR_W-1:0]              off_o
);

   logic [NUM_RGN-1:0] raw_hit;
   logic [NUM_RGN-1:0] ctrl_hit;
   logic [NUM_RGN-1:0] norm_hit;

   for (genvar r = 0; r < NUM_RGN; r++) begin : g_cmp
      assign raw_hit[r]  = ((addr_i ^ base_i[r]) & ~smask_i[r]) == '0;
      assign ctrl_hit[r] = raw_hit[r] & flags_i[r][FLG_CTRL];
      assign norm_hit[r] = raw_hit[r] & flags_i[r][FLG_VALID] & ~flags_i[r][FLG_CTRL];
   end

   // lowest-index ordinary region first, then a controller hit overrides it
   always_comb begin
      idx_o = '0;
      hit_o = 1'b0;
      for (int r = NUM_RGN - 1; r >= 0; r--) begin
         if (norm_hit[r]) begin
            idx_o = IDX_W'(r);
            hit_o = 1'b1;
         end
      end
      for (int r = NUM_RGN - 1; r >= 0; r--) begin
         if (ctrl_hit[r]) begin
            idx_o = IDX_W'(r);
            hit_o = 1'b1;
         end
      end
   end

   assign off_o = addr_i & smask_i[idx_o];

endmodule

// File: rtl/rd_wait_fsm.sv
module rd_wait_fsm #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] load_i,
   output logic             busy_o,
   output logic             done_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_o) begin
         if (start_i) begin
            busy_o <= 1'b1;
            cnt_q  <= load_i;
         end
      end else if (cnt_q == '0) begin
         busy_o <= 1'b0;
      end else begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign done_o = busy_o && (cnt_q == '0);

   // R12: completion is a single-cycle strobe
   p_ready_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: an accepted request always occupies the decoder on the next cycle
   p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

endmodule

// File: rtl/region_decoder.sv
module region_decoder
   import region_decoder_pkg::*;
#(
   parameter  int NUM_RGN = 4,
   parameter  int ADDR_W  = 32,
   parameter  int DATA_W  = 32,
   parameter  int DLY_W   = 8,
   localparam int IDX_W   = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_write,
   input  logic [1:0]                req_size,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [DATA_W-1:0]         req_wdata,
   output logic                      rsp_ready,
   output logic                      rsp_align_fault,
   output logic                      rsp_bus_err,
   output logic [DATA_W-1:0]         rsp_rdata,
   output logic [ADDR_W-1:0]         rsp_fault_addr,
   output logic [NUM_RGN-1:0]        tgt_sel,
   output logic                      tgt_we,
   output logic [1:0]                tgt_size,
   output logic [ADDR_W-1:0]         tgt_offset,
   output logic [DATA_W-1:0]         tgt_wdata,
   input  logic [NUM_RGN*DATA_W-1:0] tgt_rdata,
   input  logic                      cfg_we,
   input  logic [IDX_W-1:0]          cfg_idx,
   input  logic [1:0]                cfg_field,
   input  logic [ADDR_W-1:0]         cfg_wdata
);

   localparam int CNT_W = DLY_W - 1;

   // elaboration-time parameter checks
   if (NUM_RGN < 1 || NUM_RGN > 16) begin : g_bad_rgn
      $error("region_decoder: NUM_RGN must lie in 1..16");
   end
   if (DLY_W < 2 || 2 * DLY_W > ADDR_W) begin : g_bad_dly
      $error("region_decoder: DLY_W must be at least 2 and both delays must fit one config word");
   end
   if (DATA_W < 32) begin : g_bad_data
      $error("region_decoder: DATA_W must hold a word access");
   end
   if (ADDR_W < FLG_W) begin : g_bad_addr
      $error("region_decoder: ADDR_W too narrow for the flag field");
   end

   logic [NUM_RGN-1:0][ADDR_W-1:0] rg_base;
   logic [NUM_RGN-1:0][ADDR_W-1:0] rg_smask;
   logic [NUM_RGN-1:0][FLG_W-1:0]  rg_flags;
   logic [NUM_RGN-1:0][DLY_W-1:0]  rg_rdly;
   logic [NUM_RGN-1:0][DLY_W-1:0]  rg_wdly;

   logic              busy, done, accept, tbl_we;
   logic              m_hit;
   logic [IDX_W-1:0]  m_idx;
   logic [ADDR_W-1:0] m_off;
   logic              align_bad, cap_ok, bus_bad;
   logic [DLY_W-1:0]  dly_sel;
   logic [CNT_W-1:0]  wait_load;

   logic              al_q, be_q, we_q;
   logic [1:0]        size_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] addr_q, off_q;
   logic [DATA_W-1:0] wdata_q, rd_sel;
   logic              ok_q;

   assign tbl_we = cfg_we & ~busy;
   assign accept = req_valid & ~busy & ~cfg_we;

   rd_region_table #(
      .NUM_RGN (NUM_RGN),
      .ADDR_W  (ADDR_W),
      .DLY_W   (DLY_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_we),
      .wr_idx   (cfg_idx),
      .wr_field (cfg_field),
      .wr_data  (cfg_wdata),
      .base_o   (rg_base),
      .smask_o  (rg_smask),
      .flags_o  (rg_flags),
      .rdly_o   (rg_rdly),
      .wdly_o   (rg_wdly)
   );

   rd_match #(
      .NUM_RGN (NUM_RGN),
      .ADDR_W  (ADDR_W)
   ) u_match (
      .addr_i  (req_addr),
      .base_i  (rg_base),
      .smask_i (rg_smask),
      .flags_i (rg_flags),
      .hit_o   (m_hit),
      .idx_o   (m_idx),
      .off_o   (m_off)
   );

   // width legality and direction legality of the chosen region
   always_comb begin
      align_bad = 1'b0;
      cap_ok    = 1'b0;
      case (acc_size_e'(req_size))
         SZ_BYTE: cap_ok = rg_flags[m_idx][FLG_CAP8];
         SZ_HALF: begin
            align_bad = req_addr[0];
            cap_ok    = rg_flags[m_idx][FLG_CAP16];
         end
         SZ_WORD: begin
            align_bad = |req_addr[1:0];
            cap_ok    = rg_flags[m_idx][FLG_CAP32];
         end
         default: cap_ok = 1'b0;
      endcase
      dly_sel = req_write ? rg_wdly[m_idx] : rg_rdly[m_idx];
      bus_bad = ~m_hit | dly_sel[DLY_W-1] | ~cap_ok;
   end

   assign wait_load = (align_bad | bus_bad) ? '0 : dly_sel[CNT_W-1:0];

   rd_wait_fsm #(
      .CNT_W (CNT_W)
   ) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (accept),
      .load_i  (wait_load),
      .busy_o  (busy),
      .done_o  (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         al_q    <= 1'b0;
         be_q    <= 1'b0;
         we_q    <= 1'b0;
         size_q  <= '0;
         idx_q   <= '0;
         addr_q  <= '0;
         off_q   <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         al_q    <= align_bad;
         be_q    <= ~align_bad & bus_bad;
         we_q    <= req_write;
         size_q  <= req_size;
         idx_q   <= m_idx;
         addr_q  <= req_addr;
         off_q   <= m_off;
         wdata_q <= req_wdata;
      end
   end

   assign ok_q = ~al_q & ~be_q;

   for (genvar r = 0; r < NUM_RGN; r++) begin : g_sel
      assign tgt_sel[r] = busy & ok_q & (idx_q == IDX_W'(r));
   end

   assign rd_sel          = tgt_rdata[int'(idx_q)*DATA_W +: DATA_W];
   assign tgt_we          = we_q;
   assign tgt_size        = size_q;
   assign tgt_offset      = off_q;
   assign tgt_wdata       = wdata_q;
   assign rsp_ready       = done;
   assign rsp_align_fault = done & al_q;
   assign rsp_bus_err     = done & be_q;
   assign rsp_rdata       = (done & ok_q & ~we_q) ? rd_sel : '0;
   assign rsp_fault_addr  = (done & ~ok_q) ? addr_q : '0;

   // R5: never more than one target driven
   p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tgt_sel));

   // R6: a faulting completion leaves every target idle
   p_fault_no_tgt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_align_fault || rsp_bus_err) |-> (tgt_sel == '0));

   // R7: failed access returns zero data
   p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_bus_err |-> (rsp_rdata == '0));

   // R8: the selection does not move while wait states run
   p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rsp_ready) |=> $stable(tgt_sel) && $stable(tgt_offset));

   // R11: table contents frozen against writes during an access
   p_cfg_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_we) |=> ($stable(rg_base) && $stable(rg_flags) && $stable(rg_smask)
                            && $stable(rg_rdly) && $stable(rg_wdly)));

   // R12: fault kinds exclusive
   p_fault_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_align_fault && rsp_bus_err));

endmodule

// File: tb/region_decoder_tb.sv
module region_decoder_tb;

   localparam int NR = 4;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int NV = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]    req_size = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_ready, rsp_align_fault, rsp_bus_err;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] rsp_fault_addr;
   logic [NR-1:0] tgt_sel;
   logic          tgt_we;
   logic [1:0]    tgt_size;
   logic [AW-1:0] tgt_offset;
   logic [DW-1:0] tgt_wdata;
   logic [NR*DW-1:0] tgt_rdata;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_idx = '0;
   logic [1:0]    cfg_field = '0;
   logic [AW-1:0] cfg_wdata = '0;

   int n_checks = 0;
   int n_err    = 0;
   bit finished = 1'b0;

   int            g_cyc;
   logic          g_al, g_be, g_we;
   logic [DW-1:0] g_rd, g_wd;
   logic [AW-1:0] g_fa, g_off;
   logic [NR-1:0] g_sel;

   always #10 clk = ~clk;   // 50 MHz

   region_decoder #(.NUM_RGN(NR), .ADDR_W(AW), .DATA_W(DW), .DLY_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_ready(rsp_ready), .rsp_align_fault(rsp_align_fault), .rsp_bus_err(rsp_bus_err),
      .rsp_rdata(rsp_rdata), .rsp_fault_addr(rsp_fault_addr),
      .tgt_sel(tgt_sel), .tgt_we(tgt_we), .tgt_size(tgt_size), .tgt_offset(tgt_offset),
      .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata)
   );

   // target model: region r answers {4'hA, r, offset[23:0]}
   always_comb begin
      for (int r = 0; r < NR; r++) begin
         tgt_rdata[r*DW +: DW] = {4'hA, 4'(r), tgt_offset[23:0]};
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg(input int idx, input int fld, input logic [31:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_field = 2'(fld); cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // present a request, wait for completion, capture the response and target view
   task automatic access(input logic w, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
      g_cyc = 0;
      do begin
         @(negedge clk);
         g_cyc++;
      end while (!rsp_ready && g_cyc < 40);
      g_al = rsp_align_fault; g_be = rsp_bus_err; g_rd = rsp_rdata; g_fa = rsp_fault_addr;
      g_sel = tgt_sel; g_off = tgt_offset; g_wd = tgt_wdata; g_we = tgt_we;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R12 ready single cycle", 32'(rsp_ready), 32'd0);
   endtask

   // {tag4, write1, size2, addr32, kind2 (0 ok,1 align,2 bus), region2, cycles4, offset32}
   localparam logic [78:0] VEC [NV] = '{
      {4'd3,  1'b0, 2'd2, 32'h0000_0010, 2'd0, 2'd0, 4'd1, 32'h0000_0010}, // R3 plain word read
      {4'd8,  1'b1, 2'd2, 32'h0000_0020, 2'd0, 2'd0, 4'd2, 32'h0000_0020}, // R8 write delay 1
      {4'd5,  1'b0, 2'd1, 32'h0000_0802, 2'd0, 2'd0, 4'd1, 32'h0000_0802}, // R5 overlap, low index
      {4'd2,  1'b0, 2'd0, 32'h0003_03FF, 2'd0, 2'd1, 4'd3, 32'h0000_03FF}, // R2 rounded size
      {4'd9,  1'b1, 2'd0, 32'h0003_0004, 2'd2, 2'd0, 4'd1, 32'h0000_0000}, // R9 forbidden write
      {4'd10, 1'b0, 2'd1, 32'h0003_0002, 2'd2, 2'd0, 4'd1, 32'h0000_0000}, // R10 no half-word
      {4'd4,  1'b0, 2'd2, 32'h0001_4000, 2'd0, 2'd3, 4'd2, 32'h0000_4000}, // R4 ctrl, valid clear
      {4'd8,  1'b1, 2'd1, 32'h0001_0006, 2'd0, 2'd3, 4'd3, 32'h0000_0006}, // R8 ctrl write delay 2
      {4'd6,  1'b0, 2'd2, 32'h0000_0012, 2'd1, 2'd0, 4'd1, 32'h0000_0000}, // R6 word misaligned
      {4'd6,  1'b1, 2'd1, 32'h0000_0011, 2'd1, 2'd0, 4'd1, 32'h0000_0000}, // R6 half misaligned
      {4'd7,  1'b0, 2'd2, 32'h0004_0000, 2'd2, 2'd0, 4'd1, 32'h0000_0000}, // R7 unmapped
      {4'd6,  1'b0, 2'd0, 32'h0000_0013, 2'd0, 2'd0, 4'd1, 32'h0000_0013}, // R6 byte any address
      {4'd2,  1'b0, 2'd2, 32'h0003_0400, 2'd2, 2'd0, 4'd1, 32'h0000_0000}, // R2 past rounded end
      {4'd10, 1'b0, 2'd3, 32'h0000_0000, 2'd2, 2'd0, 4'd1, 32'h0000_0000}  // R10 reserved size
   };

   task automatic run_vec(input logic [78:0] v, input int i);
      string         tag;
      logic          w;
      logic [1:0]    sz, kind, rg;
      logic [31:0]   a, off, wd;
      int            cyc;
      tag  = $sformatf("R%0d vec%0d", v[78:75], i);
      w    = v[74];
      sz   = v[73:72];
      a    = v[71:40];
      kind = v[39:38];
      rg   = v[37:36];
      cyc  = int'(v[35:32]);
      off  = v[31:0];
      wd   = 32'hC0DE_0000 | 32'(i);
      access(w, sz, a, wd);
      chk({tag, " cycles"}, 32'(g_cyc), 32'(cyc));
      chk({tag, " align flag"}, 32'(g_al), 32'(kind == 2'd1));
      chk({tag, " bus flag"}, 32'(g_be), 32'(kind == 2'd2));
      if (kind == 2'd0) begin
         chk({tag, " select"}, 32'(g_sel), 32'(4'b0001 << rg));
         chk({tag, " offset"}, g_off, off);
         if (w) begin
            chk({tag, " we"}, 32'(g_we), 32'd1);
            chk({tag, " wdata"}, g_wd, wd);
            chk({tag, " rdata"}, g_rd, 32'd0);
         end else begin
            chk({tag, " rdata"}, g_rd, {4'hA, 2'b00, rg, off[23:0]});
         end
      end else begin
         chk({tag, " no select"}, 32'(g_sel), 32'd0);
         chk({tag, " fault addr"}, g_fa, a);
         chk({tag, " rdata zero"}, g_rd, 32'd0);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ready low after reset", 32'(rsp_ready), 32'd0);
      chk("R1 no target after reset", 32'(tgt_sel), 32'd0);
      access(1'b0, 2'd2, 32'h0000_0000, 32'd0);
      chk("R1 empty table bus error", 32'(g_be), 32'd1);
      chk("R1 empty table cycles", 32'(g_cyc), 32'd1);
      chk("R1 empty table rdata", g_rd, 32'd0);

      // program the table
      cfg(0, 0, 32'h0000_0000); cfg(0, 1, 32'h0000_1000); cfg(0, 2, 32'h1D); cfg(0, 3, 32'h0100);
      cfg(1, 0, 32'h0003_0000); cfg(1, 1, 32'h0000_0300); cfg(1, 2, 32'h15); cfg(1, 3, 32'hFF02);
      cfg(2, 0, 32'h0000_0800); cfg(2, 1, 32'h0000_0800); cfg(2, 2, 32'h1D); cfg(2, 3, 32'h0003);
      cfg(3, 0, 32'h0001_0000); cfg(3, 1, 32'h0001_0000); cfg(3, 2, 32'h1E); cfg(3, 3, 32'h0201);

      for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

      // R11: table write during an access is discarded
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_size = 2'd0; req_addr = 32'h0003_0000;
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 2'd0; cfg_field = 2'd3; cfg_wdata = 32'h0105;
      @(negedge clk);
      cfg_we = 1'b0;
      while (!rsp_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      access(1'b0, 2'd2, 32'h0000_0010, 32'd0);
      chk("R11 delay unchanged by blocked write", 32'(g_cyc), 32'd1);

      // R11: request waits while a table write is presented
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 32'h0000_0010;
      cfg_we = 1'b1; cfg_idx = 2'd0; cfg_field = 2'd3; cfg_wdata = 32'h0100;
      @(negedge clk);
      cfg_we = 1'b0;
      chk("R11 request held off by table write", 32'(rsp_ready), 32'd0);
      @(negedge clk);
      chk("R11 request served after table write", 32'(rsp_ready), 32'd1);
      @(negedge clk);
      req_valid = 1'b0;

      // R5: clearing the valid bit of region 0 exposes region 2
      cfg(0, 2, 32'h1C);
      access(1'b0, 2'd2, 32'h0000_0804, 32'd0);
      chk("R5 invalid region skipped select", 32'(g_sel), 32'b0100);
      chk("R5 invalid region skipped offset", g_off, 32'h4);
      chk("R8 region 2 read delay 3", 32'(g_cyc), 32'd4);
      access(1'b0, 2'd2, 32'h0000_0010, 32'd0);
      chk("R5 invalid region gives bus error", 32'(g_be), 32'd1);

      // R4: controller region wins an overlap with a valid region
      cfg(2, 0, 32'h0001_2000);
      access(1'b0, 2'd2, 32'h0001_2004, 32'd0);
      chk("R4 controller wins select", 32'(g_sel), 32'b1000);
      chk("R4 controller wins offset", g_off, 32'h2004);
      chk("R4 controller wins rdata", g_rd, 32'hA300_2004);

      // R5: once the controller flag is gone, valid is required again
      cfg(3, 2, 32'h1C);
      access(1'b0, 2'd2, 32'h0001_4000, 32'd0);
      chk("R5 cleared controller needs valid", 32'(g_be), 32'd1);
      chk("R7 fault address reported", g_fa, 32'h0001_4000);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end

endmodule